// File: doc/BRIEF.md
# Keyed Configuration Port

This block gives a host byte access to a configuration register space through a window of only two I/O addresses. Address 0 of the window is an index port and address 1 is a data port. The host writes a register index to the index port. It then reads or writes the data port, and that access lands on the register the index names. The block powers up locked. Configuration access opens only when the unlock byte 0x87 is written to the index port on two index writes in a row. Writing 0xAA to the index port closes it again.

Indices below 0x30 reach a global space. That space holds a logical device number register and read-only identification bytes. Indices 0x30 and above reach the bank of the logical device currently selected. Each implemented device has an enable bit and a 16-bit base address, and the block stores these itself. Every bank access is also placed on a selected-bank bus, so that the owning device can keep the rest of its registers and return their read data.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked. Index-port and data-port reads both return 0xFF, and neither bank strobe is asserted.
- R2: Two index-port writes of 0x87 in a row unlock the port. After that, an index-port read returns the current index register, which is 0x00 after reset.
- R3: An index-port write of any other value after a single 0x87 restarts the unlock sequence. Two further 0x87 writes are then needed. Data-port accesses do not affect the sequence.
- R4: While unlocked, an index-port write of 0xAA locks the port. The index register is not changed by that write, and it keeps its value across the lock and the next unlock.
- R5: While locked, data-port writes change no register and assert no bank strobe. Index writes do not load the index register.
- R6: Index 0x20 reads the high byte of the device ID and 0x21 reads its low byte. Index 0x22 reads the revision byte. Indices 0x23 and 0x24 read 0x19 and 0x34 (manufacturer ID 0x1934, high byte first). Writes to indices 0x20 through 0x24 are dropped.
- R7: Index 0x07 is the logical device number, a full read/write byte that resets to 0x00. It selects the bank that answers indices 0x30 and above.
- R8: For a device number below NUM_DEV, index 0x30 reads {7'b0, enable}, and a write stores data bit 0. Indices 0x60 and 0x61 are the high and low bytes of that device's base address, and they reset to 0. Each device keeps its own copy.
- R9: An unlocked data-port access at an index of 0x30 or more asserts bank_wr or bank_rd in the same cycle. bank_sel carries the device number, bank_idx the index and bank_wdata the write byte. Reads at bank indices other than 0x30, 0x60 and 0x61 return bank_rdata.
- R10: Global indices below 0x30 other than 0x07 and 0x20 to 0x24 read 0x00, and writes to them are dropped.
- R11: When the device number is NUM_DEV or above, indices 0x30, 0x60 and 0x61 read 0x00, and writes to them change no stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, read data valid in the same cycle |
| bus_addr | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte while bus_rd is high, else 0 |
| bank_sel | output | 8 | Selected logical device number |
| bank_idx | output | 8 | Register index within the bank |
| bank_wr | output | 1 | Bank write strobe |
| bank_rd | output | 1 | Bank read strobe |
| bank_wdata | output | 8 | Bank write byte |
| bank_rdata | input | 8 | Read byte returned by the selected device |

## Verification
The assertions assume that the host never raises bus_wr and bus_rd in the same cycle, and that a strobe lasts one cycle for each access. The bench task issues exactly one access per clock, with a single strobe high, and it drops all strobes between accesses. The random phase draws indices from a pool of non-key values. This pool covers the identification, global, common-bank and external-bank ranges. Locking and unlocking happen only in directed steps, so the bench model always knows the key state. Device numbers are drawn partly above NUM_DEV so that the dropped-write path is also exercised.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] UNLOCK_KEY    = 8'h87;
  localparam logic [7:0] LOCK_KEY      = 8'hAA;
  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_ID_FIRST  = 8'h20;
  localparam logic [7:0] IDX_ID_LAST   = 8'h24;
  localparam logic [7:0] IDX_BANK_BASE = 8'h30;
  localparam logic [7:0] IDX_ENABLE    = 8'h30;
  localparam logic [7:0] IDX_ADDR_HI   = 8'h60;
  localparam logic [7:0] IDX_ADDR_LO   = 8'h61;
  localparam logic [7:0] LOCKED_READ   = 8'hFF;

  function automatic logic is_bank_idx(input logic [7:0] idx);
    return idx >= IDX_BANK_BASE;
  endfunction

  function automatic logic is_common_idx(input logic [7:0] idx);
    return (idx == IDX_ENABLE) || (idx == IDX_ADDR_HI) || (idx == IDX_ADDR_LO);
  endfunction

  function automatic logic is_id_idx(input logic [7:0] idx);
    return (idx >= IDX_ID_FIRST) && (idx <= IDX_ID_LAST);
  endfunction

  // Identification byte for an index in 0x20..0x24; high byte at lower index.
  function automatic logic [7:0] id_byte(input logic [7:0]  idx,
                                         input logic [15:0] dev_id,
                                         input logic [7:0]  rev,
                                         input logic [15:0] mfr_id);
    case (idx)
      8'h20:   return dev_id[15:8];
      8'h21:   return dev_id[7:0];
      8'h22:   return rev;
      8'h23:   return mfr_id[15:8];
      8'h24:   return mfr_id[7:0];
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic       idx_load
);

  key_state_e state_q, state_d;
  logic       key_open_hit;
  logic       key_lock_hit;

  assign key_open_hit = idx_wr && (wdata == UNLOCK_KEY);
  assign key_lock_hit = idx_wr && (wdata == LOCK_KEY);

  always_comb begin
    state_d = state_q;
    case (state_q)
      KEY_LOCKED: if (idx_wr) state_d = key_open_hit ? KEY_HALF : KEY_LOCKED;
      KEY_HALF:   if (idx_wr) state_d = key_open_hit ? KEY_OPEN : KEY_LOCKED;
      KEY_OPEN:   if (key_lock_hit) state_d = KEY_LOCKED;
      default:    state_d = KEY_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KEY_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == KEY_OPEN);
  assign idx_load = idx_wr && unlocked && !key_lock_hit;

  // R2
  open_from_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(state_q == KEY_HALF));

  // R3
  no_idx_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(state_q));

  // R4
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && wdata == LOCK_KEY) |=> !unlocked);

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'h5A3C,
  parameter logic [7:0]  REV    = 8'h11,
  parameter logic [15:0] MFR_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       data_wr,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] ldn_q,
  output logic [7:0] rd_byte
);

  logic ldn_we;

  assign ldn_we = unlocked && data_wr && (index == IDX_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n)      ldn_q <= 8'h00;
    else if (ldn_we) ldn_q <= wdata;
  end

  always_comb begin
    if (index == IDX_LDN)      rd_byte = ldn_q;
    else if (is_id_idx(index)) rd_byte = id_byte(index, DEV_ID, REV, MFR_ID);
    else                       rd_byte = 8'h00;
  end

  // R5
  ldn_locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(ldn_q));

endmodule

// File: rtl/cfg_dev_common.sv
module cfg_dev_common
  import cfg_port_pkg::*;
#(
  parameter int NUM_DEV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] index,
  input  logic [7:0] ldn,
  input  logic [7:0] wdata,
  output logic [7:0] rd_byte,
  output logic       hit
);

  localparam int LDN_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [NUM_DEV-1:0] en_vec;
  logic [15:0]        base_arr [NUM_DEV];
  logic               in_range;
  logic [LDN_W-1:0]   ldn_l;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic        en_d;
    logic [15:0] base_d;
    logic        sel_d;

    assign sel_d = (ldn == 8'(d));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_d   <= 1'b0;
        base_d <= 16'h0000;
      end else if (wr_en && sel_d) begin
        case (index)
          IDX_ENABLE:  en_d         <= wdata[0];
          IDX_ADDR_HI: base_d[15:8] <= wdata;
          IDX_ADDR_LO: base_d[7:0]  <= wdata;
          default: ;
        endcase
      end
    end

    assign en_vec[d]   = en_d;
    assign base_arr[d] = base_d;
  end

  assign in_range = (ldn < 8'(NUM_DEV));
  assign ldn_l    = ldn[LDN_W-1:0];
  assign hit      = is_common_idx(index);

  always_comb begin
    rd_byte = 8'h00;
    if (in_range) begin
      case (index)
        IDX_ENABLE:  rd_byte = {7'b0, en_vec[ldn_l]};
        IDX_ADDR_HI: rd_byte = base_arr[ldn_l][15:8];
        IDX_ADDR_LO: rd_byte = base_arr[ldn_l][7:0];
        default:     rd_byte = 8'h00;
      endcase
    end
  end

  // R8
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_vec));

  // R11
  out_of_range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> $stable(en_vec));

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int          NUM_DEV = 8,
  parameter logic [15:0] DEV_ID  = 16'h5A3C,
  parameter logic [7:0]  REV     = 8'h11,
  parameter logic [15:0] MFR_ID  = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] bank_sel,
  output logic [7:0] bank_idx,
  output logic       bank_wr,
  output logic       bank_rd,
  output logic [7:0] bank_wdata,
  input  logic [7:0] bank_rdata
);

  logic       idx_wr;
  logic       data_wr;
  logic       data_rd;
  logic       unlocked;
  logic       idx_load;
  logic [7:0] index_q;
  logic [7:0] ldn_q;
  logic [7:0] glob_rd;
  logic [7:0] comm_rd;
  logic       comm_hit;
  logic       bank_space;
  logic [7:0] data_rd_byte;

  assign idx_wr  = bus_wr && !bus_addr;
  assign data_wr = bus_wr &&  bus_addr;
  assign data_rd = bus_rd &&  bus_addr;

  cfg_key_fsm u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (bus_wdata),
    .unlocked (unlocked),
    .idx_load (idx_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        index_q <= 8'h00;
    else if (idx_load) index_q <= bus_wdata;
  end

  cfg_global_regs #(
    .DEV_ID (DEV_ID),
    .REV    (REV),
    .MFR_ID (MFR_ID)
  ) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (unlocked),
    .data_wr  (data_wr),
    .index    (index_q),
    .wdata    (bus_wdata),
    .ldn_q    (ldn_q),
    .rd_byte  (glob_rd)
  );

  assign bank_space = is_bank_idx(index_q);

  cfg_dev_common #(
    .NUM_DEV (NUM_DEV)
  ) u_comm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (unlocked && data_wr && bank_space),
    .index   (index_q),
    .ldn     (ldn_q),
    .wdata   (bus_wdata),
    .rd_byte (comm_rd),
    .hit     (comm_hit)
  );

  assign bank_sel   = ldn_q;
  assign bank_idx   = index_q;
  assign bank_wdata = bus_wdata;
  assign bank_wr    = unlocked && data_wr && bank_space;
  assign bank_rd    = unlocked && data_rd && bank_space;

  always_comb begin
    if (!unlocked)       data_rd_byte = LOCKED_READ;
    else if (!bank_space) data_rd_byte = glob_rd;
    else if (comm_hit)   data_rd_byte = comm_rd;
    else                 data_rd_byte = bank_rdata;
  end

  always_comb begin
    if (!bus_rd)       bus_rdata = 8'h00;
    else if (bus_addr) bus_rdata = data_rd_byte;
    else               bus_rdata = unlocked ? index_q : LOCKED_READ;
  end

  // R5
  locked_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!bank_wr && !bank_rd));

  // R5
  locked_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(index_q));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank_wr, bank_rd}));

endmodule

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb_top;

  localparam int CLK_P   = 10;
  localparam int NUM_DEV = 8;
  localparam logic [15:0] DEV_ID = 16'h5A3C;
  localparam logic [7:0]  REV    = 8'h11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata, bank_sel, bank_idx, bank_wdata, bank_rdata;
  logic       bank_wr, bank_rd;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_idx;
  logic [7:0]  m_ldn;
  logic        m_en   [NUM_DEV];
  logic [15:0] m_base [NUM_DEV];

  // sampled values of the last access
  logic [7:0] s_rdata, s_sel, s_idx, s_wd;
  logic       s_bwr, s_brd;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] bank_fn(input logic [7:0] s, input logic [7:0] i);
    return {s[3:0], 4'h0} ^ i ^ 8'h5A;
  endfunction

  assign bank_rdata = bank_fn(bank_sel, bank_idx);

  keyed_cfg_port #(.NUM_DEV(NUM_DEV), .DEV_ID(DEV_ID), .REV(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bank_sel(bank_sel), .bank_idx(bank_idx), .bank_wr(bank_wr),
    .bank_rd(bank_rd), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] idx, input logic [7:0] ldn);
    if (idx < 8'h30) begin
      case (idx)
        8'h07: return ldn;
        8'h20: return DEV_ID[15:8];
        8'h21: return DEV_ID[7:0];
        8'h22: return REV;
        8'h23: return 8'h19;
        8'h24: return 8'h34;
        default: return 8'h00;
      endcase
    end
    if (idx == 8'h30 || idx == 8'h60 || idx == 8'h61) begin
      if (ldn >= NUM_DEV) return 8'h00;
      if (idx == 8'h30) return {7'b0, m_en[ldn[2:0]]};
      if (idx == 8'h60) return m_base[ldn[2:0]][15:8];
      return m_base[ldn[2:0]][7:0];
    end
    return bank_fn(ldn, idx);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input bit addr, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_addr = addr; bus_wdata = d;
    #(CLK_P/4);
    s_rdata = bus_rdata; s_sel = bank_sel; s_idx = bank_idx;
    s_wd = bank_wdata; s_bwr = bank_wr; s_brd = bank_rd;
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 8'h00;
  endtask

  task automatic wr_idx(input logic [7:0] d); op(1, 0, d); endtask
  task automatic wr_dat(input logic [7:0] d); op(1, 1, d); endtask
  task automatic rd_idx(); op(0, 0, 8'h00); endtask
  task automatic rd_dat(); op(0, 1, 8'h00); endtask

  // model update on an unlocked data write
  task automatic m_write(input logic [7:0] d);
    if (m_idx == 8'h07) m_ldn = d;
    else if (m_ldn < NUM_DEV) begin
      if (m_idx == 8'h30) m_en[m_ldn[2:0]] = d[0];
      if (m_idx == 8'h60) m_base[m_ldn[2:0]][15:8] = d;
      if (m_idx == 8'h61) m_base[m_ldn[2:0]][7:0] = d;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pool [12];
    pool = '{8'h07, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h10, 8'h30,
             8'h60, 8'h61, 8'h45, 8'h7F};
    m_idx = 8'h00; m_ldn = 8'h00;
    for (int i = 0; i < NUM_DEV; i++) begin m_en[i] = 0; m_base[i] = 16'h0; end
    void'($urandom(32'd1234));

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_idx(); chk("R1 idx locked", s_rdata, 8'hFF);
    rd_dat(); chk("R1 data locked", s_rdata, 8'hFF);
    chk("R1 strobes", {6'b0, s_bwr, s_brd}, 8'h00);

    // R2 single key not enough
    wr_idx(8'h87); rd_dat(); chk("R2 half key", s_rdata, 8'hFF);
    // R3 broken sequence
    wr_idx(8'h55); wr_idx(8'h87); rd_dat(); chk("R3 restart", s_rdata, 8'hFF);
    wr_dat(8'h00); // data access does not break the sequence
    wr_idx(8'h87);
    rd_idx(); chk("R2 unlocked idx", s_rdata, 8'h00);
    rd_dat(); chk("R3 data ignored in seq, ldn", s_rdata, 8'h00);

    // R6 identification
    wr_idx(8'h20); rd_dat(); chk("R6 dev hi", s_rdata, DEV_ID[15:8]);
    wr_dat(8'h00); rd_dat(); chk("R6 dev hi write dropped", s_rdata, DEV_ID[15:8]);
    wr_idx(8'h21); rd_dat(); chk("R6 dev lo", s_rdata, DEV_ID[7:0]);
    wr_idx(8'h22); rd_dat(); chk("R6 rev", s_rdata, REV);
    wr_idx(8'h23); wr_dat(8'hEE); rd_dat(); chk("R6 mfr hi", s_rdata, 8'h19);
    wr_idx(8'h24); rd_dat(); chk("R6 mfr lo", s_rdata, 8'h34);

    // R7 device number
    wr_idx(8'h07); wr_dat(8'h03); rd_dat(); chk("R7 ldn", s_rdata, 8'h03);
    m_ldn = 8'h03;

    // R8 / R9 common registers and bank bus
    wr_idx(8'h30); wr_dat(8'hFF);
    chk("R9 bank_wr", {7'b0, s_bwr}, 8'h01);
    chk("R9 bank_sel", s_sel, 8'h03);
    chk("R9 bank_idx", s_idx, 8'h30);
    chk("R9 bank_wdata", s_wd, 8'hFF);
    m_en[3] = 1;
    rd_dat(); chk("R8 enable bit", s_rdata, 8'h01);
    chk("R9 bank_rd", {7'b0, s_brd}, 8'h01);
    wr_idx(8'h60); wr_dat(8'hAB); wr_idx(8'h61); wr_dat(8'hCD);
    m_base[3] = 16'hABCD;
    wr_idx(8'h60); rd_dat(); chk("R8 base hi", s_rdata, 8'hAB);
    wr_idx(8'h61); rd_dat(); chk("R8 base lo", s_rdata, 8'hCD);
    wr_idx(8'h07); wr_dat(8'h05); m_ldn = 8'h05;
    wr_idx(8'h30); rd_dat(); chk("R8 other dev enable", s_rdata, 8'h00);
    wr_idx(8'h60); rd_dat(); chk("R8 other dev base", s_rdata, 8'h00);
    wr_idx(8'h45); rd_dat(); chk("R9 ext bank read", s_rdata, bank_fn(8'h05, 8'h45));

    // R10 undefined global
    wr_idx(8'h10); wr_dat(8'h77); rd_dat(); chk("R10 undefined", s_rdata, 8'h00);

    // R11 out-of-range device
    wr_idx(8'h07); wr_dat(8'h20); m_ldn = 8'h20;
    wr_idx(8'h30); wr_dat(8'h01); rd_dat(); chk("R11 enable reads 0", s_rdata, 8'h00);
    wr_idx(8'h07); wr_dat(8'h00); m_ldn = 8'h00;
    wr_idx(8'h30); rd_dat(); chk("R11 dev0 untouched", s_rdata, 8'h00);
    wr_idx(8'h07); wr_dat(8'h20); m_ldn = 8'h20;
    wr_idx(8'h45); rd_dat(); chk("R9 ext bank out of range", s_rdata, bank_fn(8'h20, 8'h45));
    m_idx = 8'h45;

    // R4 lock, R5 locked writes ignored
    wr_idx(8'hAA);
    rd_dat(); chk("R4 locked data", s_rdata, 8'hFF);
    rd_idx(); chk("R4 locked idx", s_rdata, 8'hFF);
    wr_idx(8'h07); wr_dat(8'h99);
    chk("R5 no bank_wr", {7'b0, s_bwr}, 8'h00);
    wr_idx(8'h87); wr_idx(8'h87);
    rd_idx(); chk("R4 index retained", s_rdata, 8'h45);
    wr_idx(8'h07); rd_dat(); chk("R5 ldn unchanged", s_rdata, 8'h20);
    m_idx = 8'h07;

    // random phase against the model
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      r = $urandom_range(0, 9);
      if (r < 3) begin
        m_idx = pool[$urandom_range(0, 11)];
        wr_idx(m_idx);
      end else if (r < 6) begin
        logic [7:0] d;
        d = (m_idx == 8'h07) ? 8'($urandom_range(0, 9)) : 8'($urandom);
        wr_dat(d);
        chk("R9 random bank_wr", {7'b0, s_bwr}, {7'b0, m_idx >= 8'h30});
        m_write(d);
      end else if (r < 9) begin
        rd_dat();
        chk("R7 R8 R10 random read", s_rdata, exp_read(m_idx, m_ldn));
      end else begin
        wr_idx(8'hAA);
        wr_dat(8'h5C);
        rd_dat(); chk("R5 random locked", s_rdata, 8'hFF);
        wr_idx(8'h87); wr_idx(8'h87);
        rd_idx(); chk("R4 random idx kept", s_rdata, m_idx);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule